// File: doc/BRIEF.md
# I2C Byte Engine with Configurable Acknowledge

This block moves one byte across an I2C bus under a serial clock that it generates itself. An 8-bit control register sets the clock divider, the speed mode, the acknowledge level and whether a ninth acknowledge pulse follows the byte. A host writes the register, then pulses `start` along with the direction and, for transmit, the byte. The engine sends or receives eight bits, most significant bit first, and then optionally runs the acknowledge slot. It raises `done` for one cycle when the byte is finished. Start and stop conditions, arbitration and clock stretching belong to the host.

When receiving, the engine either drives the configured acknowledge level or, for an address byte, compares the upper seven bits with its own address and pulls SDA low only on a match. When transmitting, it releases SDA in the acknowledge slot and reports the level it sampled there. The host may change the acknowledge bit at any time. Changing any other field while a byte is running aborts the byte and restarts the clock generator.

Top module: `i2c_byte_engine`

## Requirements
- R1: Register layout: bits [4:0] hold the divider code, bit 5 the fast-mode select, bit 6 the acknowledge value and bit 7 the acknowledge-clock enable. In standard mode the SCL high time is max(code,1) x STD_BASE system clocks (8 by default), so a code of 0 behaves like a code of 1.
- R2: With bit 5 set and CLK_KHZ >= FAST_MIN_KHZ, the SCL high time is max(code,1) x STD_BASE/4 clocks. When CLK_KHZ is below FAST_MIN_KHZ, bit 5 is ignored and standard timing applies.
- R3: On transmit, the byte appears on SDA most significant bit first, one bit per SCL pulse. SDA changes only while SCL is low and has been low for at least one clock.
- R4: On receive, SDA is sampled in the first clock after each SCL rise and shifted in MSB first. The engine keeps SDA released (1) during the data bits, and `rx_byte` holds the byte when `done` is high.
- R5: With bit 7 at 1 the byte takes nine SCL pulses. With bit 7 at 0 it takes exactly eight.
- R6: On a received data byte with the acknowledge clock on, SDA during the ninth pulse equals bit 6 (0 drives low, 1 stays high).
- R7: On transmit, SDA is released (1) during the ninth pulse. `ack_seen` equals the level sampled there and is valid while `done` is high. With no acknowledge clock, `ack_seen` reads 1.
- R8: On a received address byte (`addr_mode`=1), `addr_hit` is 1 when rx_byte[7:1] equals `own_addr`. In the acknowledge slot SDA is 0 only when bit 6 is 0 and the address matches.
- R9: A register write while busy that changes only bit 6 does not disturb the transfer, and the new value is used in the acknowledge slot.
- R10: A register write while busy that changes any bit other than bit 6 aborts the byte. On the next cycle `busy` is 0 and SCL and SDA are both 1. No `done` follows, and the written value is stored.
- R11: After reset, SCL and SDA are 1 and `busy` and `done` are 0.
- R12: `done` is a one-cycle pulse. `busy` is 0 and SCL is held low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| own_addr | input | 7 | Address this engine answers to |
| start | input | 1 | Begin one byte (ignored while busy) |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| addr_mode | input | 1 | Received byte is an address |
| tx_byte | input | 8 | Byte to transmit, taken at start |
| sda_i | input | 1 | Observed SDA bus level |
| scl_o | output | 1 | SCL drive (1 = released/high) |
| sda_o | output | 1 | SDA drive (1 = released/high) |
| busy | output | 1 | Byte in progress |
| done | output | 1 | One-cycle pulse at end of byte |
| rx_byte | output | 8 | Received byte |
| ack_seen | output | 1 | Acknowledge level sampled on transmit |
| addr_hit | output | 1 | Received address matched `own_addr` |

## Verification
The hardest situation to reach from the ports is a register write landing in the middle of a byte. Two variants matter: one touching only the acknowledge bit, which must not disturb the byte, and one touching another field, which must abort it. The bench counts clock cycles after `start` and issues each write deep inside the data bits. It then checks that the following acknowledge slot uses the new value, or that both lines are released at once and no `done` ever follows. The low-clock fast-mode rule is reached with a second instance built with a system-clock parameter below the fast-mode threshold.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

   // Control register image; the field order is the register's bit order.
   typedef struct packed {
      logic       ack_clk_en;   // bit 7
      logic       ack_val;      // bit 6
      logic       fast;         // bit 5
      logic [4:0] div;          // bits 4:0
   } eng_cfg_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } eng_phase_e;

   localparam logic [7:0] ACK_FIELD_MASK = 8'h40;

endpackage

// File: rtl/i2c_eng_clkgen.sv
module i2c_eng_clkgen #(
   parameter int STD_BASE     = 8,
   parameter int CLK_KHZ      = 50000,
   parameter int FAST_MIN_KHZ = 4000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic [4:0] div_code,
   input  logic       fast_req,
   output logic       tick,
   output logic       first
);
   localparam int FAST_BASE = STD_BASE / 4;
   localparam int CW        = $clog2(31 * STD_BASE + 1);

   generate
      if ((STD_BASE % 4) != 0 || STD_BASE < 8) begin : g_bad_base
         $error("STD_BASE must be a multiple of 4 and at least 8");
      end
   endgenerate

   logic          fast_eff;
   logic [4:0]    div_eff;
   logic [CW-1:0] lim;
   logic [CW-1:0] cnt_q;

   // Pick the fast-mode variant according to the system clock rate.
   generate
      if (CLK_KHZ >= FAST_MIN_KHZ) begin : g_fast_ok
         assign fast_eff = fast_req;
      end else begin : g_fast_blocked
         assign fast_eff = fast_req & 1'b0;
      end
   endgenerate

   always_comb begin
      div_eff = (div_code == 5'd0) ? 5'd1 : div_code;
      lim     = CW'(div_eff) * (fast_eff ? CW'(FAST_BASE) : CW'(STD_BASE));
   end

   assign tick  = (cnt_q == lim - CW'(1));
   assign first = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + CW'(1);
   end

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt_q < lim));

endmodule

// File: rtl/i2c_eng_addrcmp.sv
module i2c_eng_addrcmp #(
   parameter int AW = 7
) (
   input  logic [AW-1:0] rx_addr,
   input  logic [AW-1:0] own_addr,
   output logic          match
);
   generate
      if (AW < 1 || AW > 7) begin : g_bad_aw
         $error("AW must be between 1 and 7");
      end
   endgenerate

   assign match = (rx_addr == own_addr);

endmodule

// File: rtl/i2c_eng_bitctl.sv
module i2c_eng_bitctl
   import i2c_eng_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       rx_mode,
   input  logic       addr_mode,
   input  logic [7:0] tx_byte,
   input  logic       abort,
   input  logic       tick,
   input  logic       first,
   input  logic       ack_en,
   input  logic       ack_val,
   input  logic       addr_match,
   input  logic       sda_i,
   output logic       run,
   output logic       scl_o,
   output logic       sda_o,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       ack_seen,
   output logic       addr_hit
);
   eng_phase_e ph_q;
   logic [3:0] bit_q;
   logic [7:0] tx_q;
   logic [7:0] rx_q;
   logic       rxm_q;
   logic       adm_q;
   logic       scl_q;
   logic       sda_q;
   logic       done_q;
   logic       ack_q;
   logic       hit_q;
   logic       drive_bit;
   logic       last_pulse;

   always_comb begin
      if (bit_q[3]) begin
         if (!rxm_q)     drive_bit = 1'b1;
         else if (adm_q) drive_bit = ack_val | ~addr_match;
         else            drive_bit = ack_val;
      end else begin
         drive_bit = rxm_q ? 1'b1 : tx_q[3'd7 - bit_q[2:0]];
      end
      last_pulse = bit_q[3] || (bit_q == 4'd7 && !ack_en);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         bit_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         rxm_q  <= 1'b0;
         adm_q  <= 1'b0;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
         done_q <= 1'b0;
         ack_q  <= 1'b1;
         hit_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            ph_q  <= PH_IDLE;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
         end else begin
            case (ph_q)
               PH_IDLE: begin
                  if (start) begin
                     ph_q  <= PH_LOW;
                     bit_q <= '0;
                     scl_q <= 1'b0;
                     tx_q  <= tx_byte;
                     rxm_q <= rx_mode;
                     adm_q <= addr_mode;
                     ack_q <= 1'b1;
                     hit_q <= 1'b0;
                  end
               end
               PH_LOW: begin
                  if (first) sda_q <= drive_bit;
                  if (tick) begin
                     ph_q  <= PH_HIGH;
                     scl_q <= 1'b1;
                  end
               end
               PH_HIGH: begin
                  if (first) begin
                     if (!bit_q[3])   rx_q  <= {rx_q[6:0], sda_i};
                     else if (!rxm_q) ack_q <= sda_i;
                  end
                  if (tick) begin
                     scl_q <= 1'b0;
                     if (last_pulse) begin
                        ph_q   <= PH_IDLE;
                        done_q <= 1'b1;
                        hit_q  <= rxm_q & adm_q & addr_match;
                     end else begin
                        ph_q  <= PH_LOW;
                        bit_q <= bit_q + 4'd1;
                     end
                  end
               end
               default: ph_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign run      = (ph_q != PH_IDLE);
   assign scl_o    = scl_q;
   assign sda_o    = sda_q;
   assign done     = done_q;
   assign rx_byte  = rx_q;
   assign ack_seen = ack_q;
   assign addr_hit = hit_q;

   // R3
   sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_q) && !$past(abort)) |-> (!scl_q && !$past(scl_q)));

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (ph_q == PH_IDLE && !scl_q));

   // R5
   ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE && bit_q[3]) |-> (ack_en && bit_q == 4'd8));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_eng_pkg::*;
#(
   parameter int STD_BASE     = 8,
   parameter int CLK_KHZ      = 50000,
   parameter int FAST_MIN_KHZ = 4000,
   parameter int AW           = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [7:0]    cfg_wdata,
   input  logic [AW-1:0] own_addr,
   input  logic          start,
   input  logic          rx_mode,
   input  logic          addr_mode,
   input  logic [7:0]    tx_byte,
   input  logic          sda_i,
   output logic          scl_o,
   output logic          sda_o,
   output logic          busy,
   output logic          done,
   output logic [7:0]    rx_byte,
   output logic          ack_seen,
   output logic          addr_hit
);
   eng_cfg_t cfg_q;
   logic     nonack_diff;
   logic     abort;
   logic     tick;
   logic     first;
   logic     match;

   assign nonack_diff = |((cfg_wdata ^ cfg_q) & ~ACK_FIELD_MASK);
   assign abort       = cfg_wr & busy & nonack_diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_wr) cfg_q <= eng_cfg_t'(cfg_wdata);
   end

   i2c_eng_clkgen #(
      .STD_BASE     (STD_BASE),
      .CLK_KHZ      (CLK_KHZ),
      .FAST_MIN_KHZ (FAST_MIN_KHZ)
   ) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!busy || abort),
      .div_code (cfg_q.div),
      .fast_req (cfg_q.fast),
      .tick     (tick),
      .first    (first)
   );

   i2c_eng_addrcmp #(.AW(AW)) u_addrcmp (
      .rx_addr  (rx_byte[7 -: AW]),
      .own_addr (own_addr),
      .match    (match)
   );

   i2c_eng_bitctl u_bitctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .rx_mode    (rx_mode),
      .addr_mode  (addr_mode),
      .tx_byte    (tx_byte),
      .abort      (abort),
      .tick       (tick),
      .first      (first),
      .ack_en     (cfg_q.ack_clk_en),
      .ack_val    (cfg_q.ack_val),
      .addr_match (match),
      .sda_i      (sda_i),
      .run        (busy),
      .scl_o      (scl_o),
      .sda_o      (sda_o),
      .done       (done),
      .rx_byte    (rx_byte),
      .ack_seen   (ack_seen),
      .addr_hit   (addr_hit)
   );

   // R10
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && busy && nonack_diff) |=> (!busy && scl_o && sda_o && !done));

   // R9
   ack_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && busy && !nonack_diff && !done) |=> busy || done);

endmodule

// File: tb/test_i2c_byte_engine.sv
`timescale 1ns/1ps
module test_i2c_byte_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [6:0] own_addr = 7'h2D;
   logic       start = 1'b0;
   logic       rx_mode = 1'b0;
   logic       addr_mode = 1'b0;
   logic [7:0] tx_byte = '0;
   logic       sda_i;
   logic       scl_o, sda_o, busy, done, ack_seen, addr_hit;
   logic [7:0] rx_byte;
   logic       lo_scl, lo_sda, lo_busy, lo_done, lo_ack, lo_hit;
   logic [7:0] lo_rx;

   always #10 clk = ~clk;

   int checks = 0;
   int fails = 0;
   int done_cnt = 0;
   int hi_run = 0, last_hi = 0;
   int lo_run = 0, lo_last = 0;
   int rise_n = 0;
   logic [15:0] cap_sh = '0;
   logic        slv_tx = 1'b0;
   logic [7:0]  slv_data = '0;
   logic        slv_ack = 1'b1;
   logic        slv_drv = 1'b1;

   assign sda_i = sda_o & slv_drv;

   i2c_byte_engine i_i2c_byte_engine (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .own_addr(own_addr), .start(start), .rx_mode(rx_mode),
      .addr_mode(addr_mode), .tx_byte(tx_byte), .sda_i(sda_i),
      .scl_o(scl_o), .sda_o(sda_o), .busy(busy), .done(done),
      .rx_byte(rx_byte), .ack_seen(ack_seen), .addr_hit(addr_hit)
   );

   i2c_byte_engine #(.CLK_KHZ(2000)) i_lowclk (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .own_addr(own_addr), .start(start), .rx_mode(1'b0),
      .addr_mode(1'b0), .tx_byte(tx_byte), .sda_i(1'b1),
      .scl_o(lo_scl), .sda_o(lo_sda), .busy(lo_busy), .done(lo_done),
      .rx_byte(lo_rx), .ack_seen(lo_ack), .addr_hit(lo_hit)
   );

   always @(negedge clk) begin
      if (done) done_cnt++;
      if (scl_o) hi_run++;
      else begin
         if (hi_run > 0) last_hi = hi_run;
         hi_run = 0;
      end
      if (lo_scl) lo_run++;
      else begin
         if (lo_run > 0) lo_last = lo_run;
         lo_run = 0;
      end
   end

   // Bus partner model: captures engine SDA at each SCL rise and drives its own bits after each fall.
   always @(posedge scl_o) begin
      cap_sh = {cap_sh[14:0], sda_o};
      rise_n++;
   end

   always @(negedge scl_o) begin
      if (rise_n > 0) begin
         if (slv_tx && rise_n < 8)        slv_drv = slv_data[7 - rise_n];
         else if (!slv_tx && rise_n == 8) slv_drv = slv_ack;
         else                             slv_drv = 1'b1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] cfgv(input logic ackclk, input logic ackv,
                                       input logic fast, input logic [4:0] code);
      return {ackclk, ackv, fast, code};
   endfunction

   function automatic int half(input logic fast, input logic [4:0] code);
      return ((code == 5'd0) ? 1 : int'(code)) * (fast ? 2 : 8);
   endfunction

   task automatic wr_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic launch(input logic rx, input logic adr, input logic [7:0] b);
      @(negedge clk);
      rx_mode = rx;
      addr_mode = adr;
      tx_byte = b;
      rise_n = 0;
      cap_sh = '0;
      slv_drv = slv_tx ? slv_data[7] : 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk({req, " done reached"}, 32'(done), 32'd1);
      chk("R12 busy low at done", 32'(busy), 32'd0);
      chk("R12 scl held low at done", 32'(scl_o), 32'd0);
      @(negedge clk);
      chk("R12 done single cycle", 32'(done), 32'd0);
   endtask

   task automatic t_reset();
      chk("R11 scl after reset", 32'(scl_o), 32'd1);
      chk("R11 sda after reset", 32'(sda_o), 32'd1);
      chk("R11 busy after reset", 32'(busy), 32'd0);
      chk("R11 done after reset", 32'(done), 32'd0);
   endtask

   task automatic t_tx(input logic [4:0] code, input logic fast, input logic ackclk,
                       input logic [7:0] data, input logic sack);
      wr_cfg(cfgv(ackclk, 1'b0, fast, code));
      slv_tx = 1'b0;
      slv_ack = sack;
      launch(1'b0, 1'b0, data);
      wait_done("R3 tx");
      chk("R5 pulse count", 32'(rise_n), ackclk ? 32'd9 : 32'd8);
      if (ackclk) begin
         chk("R3 tx bits MSB first", 32'(cap_sh[8:1]), 32'(data));
         chk("R7 sda released in ack slot", 32'(cap_sh[0]), 32'd1);
         chk("R7 ack_seen", 32'(ack_seen), 32'(sack));
      end else begin
         chk("R3 tx bits MSB first", 32'(cap_sh[7:0]), 32'(data));
         chk("R7 ack_seen without ack clock", 32'(ack_seen), 32'd1);
      end
      chk(fast ? "R2 fast high time" : "R1 std high time", 32'(last_hi), 32'(half(fast, code)));
   endtask

   task automatic t_rx(input logic ackclk, input logic ackv, input logic adr,
                       input logic [7:0] data);
      logic exp_ack;
      wr_cfg(cfgv(ackclk, ackv, 1'b0, 5'd1));
      slv_tx = 1'b1;
      slv_data = data;
      launch(1'b1, adr, 8'h00);
      wait_done("R4 rx");
      chk("R4 rx_byte", 32'(rx_byte), 32'(data));
      if (adr) begin
         exp_ack = ackv | (data[7:1] != own_addr);
         chk("R8 addr_hit", 32'(addr_hit), 32'(data[7:1] == own_addr));
         chk("R8 addr ack level", 32'(cap_sh[0]), 32'(exp_ack));
         chk("R4 sda released in data", 32'(cap_sh[8:1]), 32'hFF);
      end else if (ackclk) begin
         chk("R6 data ack level", 32'(cap_sh[0]), 32'(ackv));
         chk("R4 sda released in data", 32'(cap_sh[8:1]), 32'hFF);
         chk("R5 pulse count", 32'(rise_n), 32'd9);
      end else begin
         chk("R5 pulse count no ack", 32'(rise_n), 32'd8);
         chk("R4 sda released in data", 32'(cap_sh[7:0]), 32'hFF);
      end
   endtask

   task automatic t_ack_live();
      wr_cfg(cfgv(1'b1, 1'b1, 1'b0, 5'd1));
      slv_tx = 1'b1;
      slv_data = 8'h96;
      launch(1'b1, 1'b0, 8'h00);
      repeat (20) @(negedge clk);
      wr_cfg(cfgv(1'b1, 1'b0, 1'b0, 5'd1));
      chk("R9 busy after ack-only write", 32'(busy), 32'd1);
      wait_done("R9 live ack");
      chk("R9 new ack value used", 32'(cap_sh[0]), 32'd0);
      chk("R9 data intact", 32'(rx_byte), 32'h96);
   endtask

   task automatic t_abort();
      int snap;
      wr_cfg(cfgv(1'b1, 1'b0, 1'b0, 5'd3));
      slv_tx = 1'b0;
      slv_ack = 1'b0;
      launch(1'b0, 1'b0, 8'h00);
      repeat (30) @(negedge clk);
      snap = done_cnt;
      wr_cfg(cfgv(1'b1, 1'b0, 1'b0, 5'd5));
      chk("R10 busy dropped", 32'(busy), 32'd0);
      chk("R10 scl released", 32'(scl_o), 32'd1);
      chk("R10 sda released", 32'(sda_o), 32'd1);
      repeat (200) @(negedge clk);
      chk("R10 no done after abort", 32'(done_cnt), 32'(snap));
      launch(1'b0, 1'b0, 8'h55);
      wait_done("R10 after abort");
      chk("R10 new divider stored", 32'(last_hi), 32'd40);
   endtask

   task automatic t_lowclk();
      int n = 0;
      while (lo_busy && n < 5000) begin @(negedge clk); n++; end
      wr_cfg(cfgv(1'b0, 1'b0, 1'b1, 5'd2));
      slv_tx = 1'b0;
      launch(1'b0, 1'b0, 8'hC7);
      wait_done("R2 low clock");
      chk("R2 fast honoured at high clock", 32'(last_hi), 32'd4);
      n = 0;
      while (lo_busy && n < 5000) begin @(negedge clk); n++; end
      @(negedge clk);
      chk("R2 fast ignored at low clock", 32'(lo_last), 32'd16);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx(5'd1, 1'b0, 1'b1, 8'hA5, 1'b0);   // R1 R3 R5 R7
      t_tx(5'd0, 1'b0, 1'b1, 8'h3C, 1'b1);   // R1 code 0
      t_tx(5'd2, 1'b1, 1'b0, 8'h81, 1'b0);   // R2 R5 R7
      t_rx(1'b1, 1'b0, 1'b0, 8'h5A);         // R4 R6
      t_rx(1'b1, 1'b1, 1'b0, 8'hC3);         // R6
      t_rx(1'b0, 1'b0, 1'b0, 8'h27);         // R5
      t_rx(1'b1, 1'b0, 1'b1, 8'h5B);         // R8 match
      t_rx(1'b1, 1'b0, 1'b1, 8'h5A & 8'hFE ^ 8'h02); // R8 mismatch
      t_rx(1'b1, 1'b1, 1'b1, 8'h5A);         // R8 match, ack off
      t_ack_live();                          // R9
      t_abort();                             // R10
      t_lowclk();                            // R2
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule